// File: doc/BRIEF.md
# Flash Image Programming Sequencer

This block takes a flash image from a local image memory, one entry at a time, and writes it into an attached parallel flash device. Each entry carries an address, a data word and a flag that marks the final entry. For every entry whose data is not the erased value, the sequencer runs a fixed bus sequence. It presents the address on its own, then the data, then holds the write strobe low for a programmable width, then gives a recovery interval of the same width. After that it samples the device ready line until the device reports that it has finished. Entries whose data word is all ones get no bus cycle at all. They are only counted.

Software or a test controller sets the segment size, the strobe width and the poll limit, then pulses `start`. The sequencer loops with no further help until it finishes the entry marked last, and it groups entries into segments as it goes. When it stops it raises `done` and holds it until the next start. Next to `done` it reports a fail flag, the failing address, the number of bytes programmed, the number of bytes stripped, the number of segments opened, and the lowest and highest addresses written. A device that never reports ready stops the run once the poll limit is reached.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `img_req`, `fl_addr_oe` and `fl_data_oe` are 0 and `fl_we_n` is 1.
- R2: Each programmed entry runs these phases in order, with no overlap: one cycle with `fl_addr_oe`=1 showing the entry address on `fl_addr`; then `fl_data_oe`=1 showing the entry data on `fl_data`; then the strobe phase, in which `fl_data_oe` stays 1 and `fl_we_n` is 0. `fl_addr_oe` and `fl_data_oe` are never 1 in the same cycle.
- R3: `fl_we_n` stays low for exactly `pulse_cycles` clock cycles in each write, and a value of 0 counts as 1. A recovery interval of the same length with `fl_we_n` high follows each write.
- R4: After recovery, the block samples `fl_ready` once per cycle. It moves on to the next entry only after it has sampled `fl_ready`=1.
- R5: Entries are programmed in the order the image memory delivers them, and each entry gets exactly one write strobe.
- R6: An entry whose data is all ones causes no address phase, data phase or strobe. It adds DATA_W/8 to `bytes_strip`.
- R7: Each entry that completes adds DATA_W/8 to `bytes_prog`.
- R8: `seg_count` counts image entries, stripped ones included, in groups of `seg_size` entries (0 counts as 1). It ends at ceil(entries / seg_size).
- R9: At start, `min_addr` is set to all ones and `max_addr` to zero. They then follow the lowest and highest addresses among programmed entries only, so an image made only of erased words leaves them at those start values.
- R10: Once the entry with `img_last`=1 completes, `done` rises with `fail`=0. `img_req` and `busy` go low, and `done` stays high until the next `start`.
- R11: If `fl_ready` is sampled low `poll_limit` times in a row for one entry (0 counts as 1), the run stops. `done` and `fail` go high and `fail_addr` holds that entry's address. `bytes_prog` does not count that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when not busy |
| seg_size | input | CNT_W | Entries per segment |
| pulse_cycles | input | CNT_W | Strobe-low and recovery width in cycles |
| poll_limit | input | CNT_W | Most not-ready samples allowed per entry |
| img_req | output | 1 | Request for the next image entry |
| img_valid | input | 1 | Image entry present this cycle |
| img_addr | input | ADDR_W | Flash address of the entry |
| img_data | input | DATA_W | Data word of the entry |
| img_last | input | 1 | Entry is the final one |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_addr_oe | output | 1 | Address phase active |
| fl_data | output | DATA_W | Flash data bus |
| fl_data_oe | output | 1 | Data being driven |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_ready | input | 1 | Device ready status |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Run stopped on poll limit |
| fail_addr | output | ADDR_W | Address of the entry that timed out |
| bytes_prog | output | STAT_W | Bytes programmed |
| bytes_strip | output | STAT_W | Erased-value bytes skipped |
| seg_count | output | STAT_W | Segments opened |
| min_addr | output | ADDR_W | Lowest programmed address |
| max_addr | output | ADDR_W | Highest programmed address |

## Verification
The assertions assume three things. First, `pulse_cycles`, `seg_size` and `poll_limit` do not change while `busy` is high. Second, the image memory presents an entry only while `img_req` is high. Third, `start` arrives only once reset has been released. The bench sets its configuration and clears its models before each start, and it leaves them alone until `done` rises. Its image model raises `img_valid` only while the request is high and only inside the configured window. Its device model pulls ready low from the first strobe cycle and holds it low for a set number of cycles, or for ever in the timeout test.

// File: rtl/flash_seq_pkg.sv
// Shared types for the flash image programming sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package flash_seq_pkg;

    // Phases of the per-entry programming sequence.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_WRITE = 3'd4,
        ST_RECOV = 3'd5,
        ST_POLL  = 3'd6,
        ST_DONE  = 3'd7
    } seq_state_t;

endpackage

// File: rtl/flash_phase_timer.sv
// Phase timer: counts the cycles spent in the current phase and reports
// when the programmed length has been reached.
// Assumes: restart is pulsed in the cycle before a timed phase begins;
// a length of 0 behaves as 1.
module flash_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    // Index of the final cycle of the phase.
    always_comb begin
        last_idx = (len == '0) ? '0 : len - 1'b1;
    end

    // Cycle counter, cleared at each phase change and saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= last_idx);

endmodule

// File: rtl/flash_seq_fsm.sv
// Sequencer control: fetches image entries, filters erased words, runs the
// address / data / strobe / recovery / poll phases and flags completion or
// a poll timeout.
// Assumes: the image memory presents an entry only while img_req is high;
// DATA_W is a multiple of 8.
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              img_valid,
    input  logic [ADDR_W-1:0] img_addr,
    input  logic [DATA_W-1:0] img_data,
    input  logic              img_last,
    input  logic              fl_ready,
    input  logic              wr_expired,
    input  logic              poll_expired,
    output logic              img_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_addr_oe,
    output logic [DATA_W-1:0] fl_data,
    output logic              fl_data_oe,
    output logic              fl_we_n,
    output logic              phase_chg,
    output logic              launch,
    output logic              ev_accept,
    output logic              ev_strip,
    output logic              ev_prog,
    output logic [ADDR_W-1:0] prog_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int LANES = DATA_W / 8;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic              done_q, fail_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic [LANES-1:0]  lane_ones;
    logic              erased;
    logic              timeout;

    // Erased-value detection, one byte lane per generated term.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ones[g] = &img_data[g*8 +: 8];
    end
    assign erased = &lane_ones;

    assign launch    = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign ev_accept = (state_q == ST_FETCH) && img_valid;
    assign ev_strip  = ev_accept && erased;
    assign ev_prog   = (state_q == ST_POLL) && fl_ready;
    assign timeout   = (state_q == ST_POLL) && !fl_ready && poll_expired;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (launch) state_d = ST_FETCH;
            ST_FETCH: begin
                if (img_valid) begin
                    if (!erased)       state_d = ST_ADDR;
                    else if (img_last) state_d = ST_DONE;
                end
            end
            ST_ADDR:  state_d = ST_DATA;
            ST_DATA:  state_d = ST_WRITE;
            ST_WRITE: if (wr_expired) state_d = ST_RECOV;
            ST_RECOV: if (wr_expired) state_d = ST_POLL;
            ST_POLL: begin
                if (fl_ready)     state_d = last_q ? ST_DONE : ST_FETCH;
                else if (timeout) state_d = ST_DONE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture of the accepted image entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            last_q <= 1'b0;
        end else if (ev_accept) begin
            addr_q <= img_addr;
            data_q <= img_data;
            last_q <= img_last;
        end
    end

    // Completion and failure flags, cleared when a new run launches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (launch) begin
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            if (state_d == ST_DONE && state_q != ST_DONE) done_q <= 1'b1;
            if (timeout) begin
                fail_q      <= 1'b1;
                fail_addr_q <= addr_q;
            end
        end
    end

    assign phase_chg  = (state_d != state_q);
    assign img_req    = (state_q == ST_FETCH);
    assign fl_addr    = addr_q;
    assign fl_addr_oe = (state_q == ST_ADDR);
    assign fl_data    = data_q;
    assign fl_data_oe = (state_q == ST_DATA) || (state_q == ST_WRITE);
    assign fl_we_n    = (state_q != ST_WRITE);
    assign prog_addr  = addr_q;
    assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done       = done_q;
    assign fail       = fail_q;
    assign fail_addr  = fail_addr_q;

    // Address and data are never driven together.
    p_oe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_addr_oe && fl_data_oe));

    // A strobe always begins straight after a data phase.
    p_we_after_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> $past(fl_data_oe) && !$past(fl_addr_oe));

    // Polling continues while the device is not ready and the limit is not hit.
    p_poll_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && !fl_ready && !poll_expired) |=> state_q == ST_POLL);

    // Failure is raised only from polling with a not-ready device.
    p_fail_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(state_q == ST_POLL) && !$past(fl_ready) && done);

    // No image requests once the run has finished.
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !img_req && !busy);

endmodule

// File: rtl/flash_stat_track.sv
// Run statistics: programmed and stripped byte totals, segment count, and
// the address range actually written.
// Assumes: seg_size is stable during a run; clear coincides with launch.
module flash_stat_track #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_accept,
    input  logic              ev_strip,
    input  logic              ev_prog,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [CNT_W-1:0]  seg_size,
    output logic [STAT_W-1:0] bytes_prog,
    output logic [STAT_W-1:0] bytes_strip,
    output logic [STAT_W-1:0] seg_count,
    output logic [ADDR_W-1:0] min_addr,
    output logic [ADDR_W-1:0] max_addr
);

    localparam logic [STAT_W-1:0] WORD_BYTES = STAT_W'(DATA_W / 8);

    logic [CNT_W-1:0]  seg_pos_q;
    logic [CNT_W:0]    seg_next;
    logic [STAT_W-1:0] prog_q, strip_q, seg_q;
    logic [ADDR_W-1:0] min_q, max_q;

    assign seg_next = {1'b0, seg_pos_q} + 1'b1;

    // Segment position and count over all accepted entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seg_pos_q <= '0;
            seg_q     <= '0;
        end else if (ev_accept) begin
            if (seg_pos_q == '0) seg_q <= seg_q + 1'b1;
            if (seg_next >= {1'b0, seg_size}) seg_pos_q <= '0;
            else                              seg_pos_q <= seg_next[CNT_W-1:0];
        end
    end

    // Byte totals for stripped and programmed entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prog_q  <= '0;
            strip_q <= '0;
        end else begin
            if (ev_strip) strip_q <= strip_q + WORD_BYTES;
            if (ev_prog)  prog_q  <= prog_q + WORD_BYTES;
        end
    end

    // Address range over programmed entries only.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            min_q <= {ADDR_W{1'b1}};
            max_q <= '0;
        end else if (ev_prog) begin
            if (prog_addr < min_q) min_q <= prog_addr;
            if (prog_addr > max_q) max_q <= prog_addr;
        end
    end

    assign bytes_prog  = prog_q;
    assign bytes_strip = strip_q;
    assign seg_count   = seg_q;
    assign min_addr    = min_q;
    assign max_addr    = max_q;

    // Programmed total only grows within a run.
    p_prog_mono_r7: assert property (@(posedge clk) disable iff (!rst_n || clear)
        $past(rst_n) && !$past(clear) |-> bytes_prog >= $past(bytes_prog));

    // Once anything is programmed the range is ordered.
    p_range_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bytes_prog != '0) |-> (min_addr <= max_addr));

    // Segment count never jumps by more than one per cycle.
    p_seg_step_r8: assert property (@(posedge clk) disable iff (!rst_n || clear)
        $past(rst_n) && !$past(clear) |-> (seg_count - $past(seg_count)) <= 1);

endmodule

// File: rtl/flash_prog_seq.sv
// Top of the flash image programming sequencer: control, two phase timers
// (strobe/recovery width and poll limit) and the statistics tracker.
// Assumes: pulse_cycles, seg_size and poll_limit are held while busy.
module flash_prog_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  seg_size,
    input  logic [CNT_W-1:0]  pulse_cycles,
    input  logic [CNT_W-1:0]  poll_limit,
    output logic              img_req,
    input  logic              img_valid,
    input  logic [ADDR_W-1:0] img_addr,
    input  logic [DATA_W-1:0] img_data,
    input  logic              img_last,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_addr_oe,
    output logic [DATA_W-1:0] fl_data,
    output logic              fl_data_oe,
    output logic              fl_we_n,
    input  logic              fl_ready,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [STAT_W-1:0] bytes_prog,
    output logic [STAT_W-1:0] bytes_strip,
    output logic [STAT_W-1:0] seg_count,
    output logic [ADDR_W-1:0] min_addr,
    output logic [ADDR_W-1:0] max_addr
);

    logic              phase_chg, launch;
    logic              wr_expired, poll_expired;
    logic              ev_accept, ev_strip, ev_prog;
    logic [ADDR_W-1:0] prog_addr;

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_valid(img_valid), .img_addr(img_addr), .img_data(img_data),
        .img_last(img_last), .fl_ready(fl_ready),
        .wr_expired(wr_expired), .poll_expired(poll_expired),
        .img_req(img_req), .fl_addr(fl_addr), .fl_addr_oe(fl_addr_oe),
        .fl_data(fl_data), .fl_data_oe(fl_data_oe), .fl_we_n(fl_we_n),
        .phase_chg(phase_chg), .launch(launch),
        .ev_accept(ev_accept), .ev_strip(ev_strip), .ev_prog(ev_prog),
        .prog_addr(prog_addr), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr)
    );

    flash_phase_timer #(.CNT_W(CNT_W)) u_wr_timer (
        .clk(clk), .rst_n(rst_n), .restart(phase_chg),
        .len(pulse_cycles), .expired(wr_expired)
    );

    flash_phase_timer #(.CNT_W(CNT_W)) u_poll_timer (
        .clk(clk), .rst_n(rst_n), .restart(phase_chg),
        .len(poll_limit), .expired(poll_expired)
    );

    flash_stat_track #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STAT_W(STAT_W)
    ) u_stats (
        .clk(clk), .rst_n(rst_n), .clear(launch),
        .ev_accept(ev_accept), .ev_strip(ev_strip), .ev_prog(ev_prog),
        .prog_addr(prog_addr), .seg_size(seg_size),
        .bytes_prog(bytes_prog), .bytes_strip(bytes_strip),
        .seg_count(seg_count), .min_addr(min_addr), .max_addr(max_addr)
    );

    // Checker-only run length of the strobe-low interval.
    logic [CNT_W:0] low_run_q;
    logic [CNT_W:0] pulse_eff;
    assign pulse_eff = (pulse_cycles == '0) ? (CNT_W+1)'(1) : {1'b0, pulse_cycles};

    // Counts consecutive cycles with the strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n || fl_we_n) low_run_q <= '0;
        else                   low_run_q <= low_run_q + 1'b1;
    end

    // Strobe-low width equals the programmed width.
    p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> low_run_q == pulse_eff);

    // Failure always comes with completion.
    p_fail_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int STAT_W = 32;
    localparam int WB     = DATA_W / 8;

    // Run table: {first, count, seg_size, pulse, busy_len, all_ff, exp_segs}
    localparam logic [55:0] CASES [5] = '{
        {8'd0,  8'd10, 8'd4, 8'd1, 8'd0, 8'd0, 8'd3},
        {8'd3,  8'd7,  8'd7, 8'd3, 8'd4, 8'd0, 8'd1},
        {8'd5,  8'd1,  8'd1, 8'd2, 8'd2, 8'd0, 8'd1},
        {8'd0,  8'd12, 8'd5, 8'd2, 8'd1, 8'd1, 8'd3},
        {8'd10, 8'd9,  8'd3, 8'd0, 8'd6, 8'd0, 8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              start = 1'b0;
    logic [CNT_W-1:0]  seg_size = 8'd1, pulse_cycles = 8'd1, poll_limit = 8'd16;
    logic              img_req, img_valid, img_last;
    logic [ADDR_W-1:0] img_addr;
    logic [DATA_W-1:0] img_data;
    logic [ADDR_W-1:0] fl_addr, fail_addr, min_addr, max_addr;
    logic [DATA_W-1:0] fl_data;
    logic              fl_addr_oe, fl_data_oe, fl_we_n, fl_ready;
    logic              busy, done, fail;
    logic [STAT_W-1:0] bytes_prog, bytes_strip, seg_count;

    int errors = 0;
    int checks = 0;

    // Bench-side configuration of the models.
    int   cfg_first = 0, cfg_cnt = 0, cfg_busy = 0;
    logic cfg_allff = 1'b0, stuck = 1'b0, clr_mon = 1'b0;

    function automatic logic [ADDR_W-1:0] addr_of(int i);
        return 32'h0000_4000 + 32'((i * 11) % 23) * 32'h10;
    endfunction

    function automatic logic [DATA_W-1:0] data_of(int i);
        if (cfg_allff || (i % 5 == 2)) return '1;
        return 16'hA500 + 16'(i) * 16'h0103;
    endfunction

    // Image memory model.
    int ptr = 0;
    always @(posedge clk) begin
        if (clr_mon) ptr <= cfg_first;
        else if (img_req && img_valid) ptr <= ptr + 1;
    end
    assign img_valid = img_req && (ptr < cfg_first + cfg_cnt);
    assign img_addr  = addr_of(ptr);
    assign img_data  = data_of(ptr);
    assign img_last  = (ptr == cfg_first + cfg_cnt - 1);

    // Flash device model and bus monitors.
    int busy_cnt = 0;
    assign fl_ready = !stuck && (busy_cnt == 0);
    logic [ADDR_W-1:0] addr_cap;
    logic [ADDR_W-1:0] log_addr [32];
    logic [DATA_W-1:0] log_data [32];
    int log_n = 0, low_run = 0, width_bad = 0, overlap = 0, exp_pulse = 1;
    logic we_prev = 1'b1;
    always @(posedge clk) begin
        if (clr_mon) begin
            busy_cnt <= 0; log_n <= 0; low_run <= 0; width_bad <= 0;
            overlap <= 0; we_prev <= 1'b1; addr_cap <= '0;
        end else begin
            if (!fl_we_n) busy_cnt <= cfg_busy;
            else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (fl_addr_oe) addr_cap <= fl_addr;
            if (fl_addr_oe && fl_data_oe) overlap <= overlap + 1;
            if (!fl_we_n && we_prev && log_n < 32) begin
                log_addr[log_n] <= addr_cap;
                log_data[log_n] <= fl_data_oe ? fl_data : '0;
                log_n <= log_n + 1;
            end
            if (!fl_we_n) low_run <= low_run + 1;
            else if (low_run != 0) begin
                if (low_run != exp_pulse) width_bad <= width_bad + 1;
                low_run <= 0;
            end
            we_prev <= fl_we_n;
        end
    end

    flash_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STAT_W(STAT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seg_size(seg_size),
        .pulse_cycles(pulse_cycles), .poll_limit(poll_limit),
        .img_req(img_req), .img_valid(img_valid), .img_addr(img_addr),
        .img_data(img_data), .img_last(img_last),
        .fl_addr(fl_addr), .fl_addr_oe(fl_addr_oe), .fl_data(fl_data),
        .fl_data_oe(fl_data_oe), .fl_we_n(fl_we_n), .fl_ready(fl_ready),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .bytes_prog(bytes_prog), .bytes_strip(bytes_strip), .seg_count(seg_count),
        .min_addr(min_addr), .max_addr(max_addr)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int first, input int cnt, input int seg, input int pulse,
                       input int busyl, input logic allff, input int plim, input logic stk);
        @(negedge clk);
        cfg_first = first; cfg_cnt = cnt; cfg_busy = busyl; cfg_allff = allff;
        stuck = stk; seg_size = 8'(seg); pulse_cycles = 8'(pulse); poll_limit = 8'(plim);
        exp_pulse = (pulse == 0) ? 1 : pulse;
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R10 run did not finish: actual=0 expected=1");
        end
    endtask

    // Expected results derived from the image and the requirements.
    task automatic check_run(input int first, input int cnt, input int exp_segs);
        int eprog = 0, estrip = 0, k = 0;
        logic [ADDR_W-1:0] emin = '1, emax = '0;
        for (int i = first; i < first + cnt; i++) begin
            if (data_of(i) == '1) estrip += WB;
            else begin
                eprog += WB;
                if (addr_of(i) < emin) emin = addr_of(i);
                if (addr_of(i) > emax) emax = addr_of(i);
                if (k < log_n) begin
                    chk("R5", "write address order", 64'(log_addr[k]), 64'(addr_of(i)));
                    chk("R2", "write data", 64'(log_data[k]), 64'(data_of(i)));
                end
                k++;
            end
        end
        chk("R6", "strobe count excludes erased", 64'(log_n), 64'(k));
        chk("R10", "done", 64'(done), 64'd1);
        chk("R10", "fail clear", 64'(fail), 64'd0);
        chk("R10", "busy low", 64'(busy), 64'd0);
        chk("R7", "bytes_prog", 64'(bytes_prog), 64'(eprog));
        chk("R6", "bytes_strip", 64'(bytes_strip), 64'(estrip));
        chk("R8", "seg_count", 64'(seg_count), 64'(exp_segs));
        chk("R9", "min_addr", 64'(min_addr), 64'(emin));
        chk("R9", "max_addr", 64'(max_addr), 64'(emax));
        chk("R3", "strobe width errors", 64'(width_bad), 64'd0);
        chk("R2", "phase overlap", 64'(overlap), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "fail", 64'(fail), 64'd0);
        chk("R1", "img_req", 64'(img_req), 64'd0);
        chk("R1", "oe", 64'({fl_addr_oe, fl_data_oe}), 64'd0);
        chk("R1", "we_n", 64'(fl_we_n), 64'd1);

        // Table walk: R2..R10 over several images, widths and busy times (R4).
        for (int c = 0; c < 5; c++) begin
            run(int'(CASES[c][55:48]), int'(CASES[c][47:40]), int'(CASES[c][39:32]),
                int'(CASES[c][31:24]), int'(CASES[c][23:16]), CASES[c][8], 16, 1'b0);
            check_run(int'(CASES[c][55:48]), int'(CASES[c][47:40]), int'(CASES[c][7:0]));
        end

        // R11: device never ready, poll limit 5
        run(0, 4, 2, 2, 0, 1'b0, 5, 1'b1);
        chk("R11", "done", 64'(done), 64'd1);
        chk("R11", "fail", 64'(fail), 64'd1);
        chk("R11", "fail_addr", 64'(fail_addr), 64'(addr_of(0)));
        chk("R11", "bytes_prog", 64'(bytes_prog), 64'd0);
        chk("R11", "single strobe", 64'(log_n), 64'd1);
        chk("R11", "busy low", 64'(busy), 64'd0);

        // R10: a fresh run clears fail, and done holds afterwards
        run(5, 1, 1, 2, 2, 1'b0, 16, 1'b0);
        check_run(5, 1, 1);
        repeat (5) @(negedge clk);
        chk("R10", "done held", 64'(done), 64'd1);
        chk("R10", "no request after done", 64'(img_req), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule